// File: doc/BRIEF.md
# Keyed Watchdog Timer

A memory-mapped watchdog built around a 32-bit down-counter. Software programs a reload value, turns the timer on through a control word and must keep writing a 16-bit key into a restart location; a write carrying any other value is dropped. If the count runs out, the block raises a reset pulse whose length and level come from a pulse-shape register, and it can also raise a one-cycle interrupt.

The count advances on one of two ticks, picked by a control bit: a strobe that the block makes by dividing its own clock, or an external 1 MHz strobe. The level of the reset output and the drive type it reports change only when one of four byte-wide codes lands in the top byte of the pulse-shape register. Writes to the other bits of that byte leave them alone. An inhibit input, when high at the moment of expiry, turns the expiry into a silent shutdown: the control word is cleared and no pulse is sent.

The bus is a single-beat valid/write/address port. Read data appears one clock after the request.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the count (byte offset 0x00) and the reload value (0x04) both read 0x014FB180, the pulse-shape register (0x18) reads 0x000000FF, the control word (0x0C) reads 0, the counter is stopped, `wdt_rst_o` is high (the inactive level for an active-low output) and `rst_push_pull_o` is low.
- R2: A write to the restart location (0x08) copies the reload value into the count only when write data bits 15:0 equal 0x4755; any other value leaves the count unchanged.
- R3: Control bit 0 is the enable. When a write changes it from 0 to 1, the count is loaded from the reload value and counting starts. When a write changes it from 1 to 0, counting stops. A write that keeps it at its current value only stores the new control bits.
- R4: Control bits 9:7 always read as zero, whatever was written to them.
- R5: Control bit 4 picks the tick. At 1 the count drops by one on each cycle where `tick_1mhz_i` is high. At 0 it drops by one every PCLK_DIV clocks of `clk`.
- R6: Expiry happens on a tick that finds the count at 1 or less. The count then reads 0 and stays at 0 through further ticks until it is loaded again.
- R7: A write to the pulse-shape register stores data bits 19:0 as the pulse width. A top byte of 0xA5 sets bit 31 and 0x5A clears it. A top byte of 0xA8 sets bit 30 and 0x8A clears it. Any other top byte leaves bits 31:30 unchanged. Bits 29:20 read as zero.
- R8: On an expiry that is not inhibited and with control bit 1 set, `wdt_rst_o` goes to its active level for width+1 clocks, starting in the clock after expiry. The active level is high when bit 31 is set and low when it is clear. With control bit 1 clear, no pulse is made.
- R9: On an expiry that is not inhibited and with control bit 2 set, `wdt_irq_o` is high for exactly one clock.
- R10: If `inhibit_i` is high at expiry, the control word is cleared to 0 and neither a reset pulse nor an interrupt is produced.
- R11: The restart location, the offsets 0x10 and 0x14, and every unmapped offset read 0. Writes to the count location and to unmapped offsets have no effect.
- R12: `rst_push_pull_o` follows bit 30 of the pulse-shape register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset; 32-bit aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the clock after a read request |
| tick_1mhz_i | input | 1 | External 1 MHz strobe, one clock wide |
| inhibit_i | input | 1 | Suppresses the reset at expiry |
| wdt_rst_o | output | 1 | Reset pulse at the programmed level |
| wdt_irq_o | output | 1 | One-clock interrupt at expiry |
| rst_push_pull_o | output | 1 | Drive-type selection for the reset pad |

## Verification
The hardest state to reach is an expiry that lines up exactly with a chosen count and a chosen control word. This matters most for the inhibited expiry and the expiry with the reset disabled, because after them the control word and the output level must show that nothing was issued. The stimulus selects the external tick and drives that strobe one clock at a time from the bench. This makes the expiry cycle exact, so the pulse length, the one-clock interrupt and the cleared control word can each be sampled in a known cycle. The divided tick is checked separately over a window of exactly PCLK_DIV clocks, which always holds one tick whatever the divider phase.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned IDX_W  = 6;

  // word indices (byte offset / 4)
  localparam logic [IDX_W-1:0] IDX_COUNT   = 6'h00;
  localparam logic [IDX_W-1:0] IDX_RELOAD  = 6'h01;
  localparam logic [IDX_W-1:0] IDX_RESTART = 6'h02;
  localparam logic [IDX_W-1:0] IDX_CTRL    = 6'h03;
  localparam logic [IDX_W-1:0] IDX_SHAPE   = 6'h06;

  localparam logic [15:0] RESTART_KEY = 16'h4755;

  // control word bit positions
  localparam int unsigned CB_EN   = 0;
  localparam int unsigned CB_RST  = 1;
  localparam int unsigned CB_IRQ  = 2;
  localparam int unsigned CB_TICK = 4;
  localparam logic [DATA_W-1:0] CTRL_RSVD = 32'h0000_0380;

  // pulse-shape register keys and bits
  localparam int unsigned SB_HIGH = 31;
  localparam int unsigned SB_PP   = 30;
  localparam logic [7:0] KEY_HIGH_SET = 8'hA5;
  localparam logic [7:0] KEY_HIGH_CLR = 8'h5A;
  localparam logic [7:0] KEY_PP_SET   = 8'hA8;
  localparam logic [7:0] KEY_PP_CLR   = 8'h8A;
endpackage

// File: rtl/kwd_tick_sel.sv
module kwd_tick_sel #(
  parameter int unsigned DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_ext_i,
  input  logic ext_tick_i,
  output logic tick_o
);
  localparam int unsigned DW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(DIV - 1);

  logic [DW-1:0] div_q, div_d;
  logic          wrap;

  always_comb begin
    wrap  = (div_q == LAST);
    div_d = wrap ? '0 : div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  assign tick_o = sel_ext_i ? ext_tick_i : wrap;
endmodule

// File: rtl/kwd_counter.sv
module kwd_counter #(
  parameter int unsigned CW = 32,
  parameter logic [CW-1:0] RESET_COUNT = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic          run_set_i,
  input  logic          run_clr_i,
  input  logic [CW-1:0] reload_i,
  input  logic          tick_i,
  output logic [CW-1:0] count_o,
  output logic          run_o,
  output logic          expire_o
);
  logic [CW-1:0] count_q, count_d;
  logic          run_q, run_d;
  logic          step;

  always_comb begin
    step     = run_q && tick_i && !load_i && !run_clr_i;
    expire_o = step && (count_q <= CW'(1));
    count_d  = count_q;
    if (load_i)        count_d = reload_i;
    else if (expire_o) count_d = '0;
    else if (step)     count_d = count_q - 1'b1;
    run_d = run_q;
    if (run_set_i)                  run_d = 1'b1;
    else if (run_clr_i || expire_o) run_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= RESET_COUNT;
      run_q   <= 1'b0;
    end else begin
      count_q <= count_d;
      run_q   <= run_d;
    end
  end

  assign count_o = count_q;
  assign run_o   = run_q;
endmodule

// File: rtl/kwd_pulse.sv
module kwd_pulse #(
  parameter int unsigned WW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [WW-1:0] width_i,
  input  logic          level_high_i,
  output logic          active_o,
  output logic          pin_o
);
  localparam int unsigned CNT_W = WW + 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (start_i)            cnt_d = {1'b0, width_i} + 1'b1;
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign active_o = (cnt_q != '0);
  assign pin_o    = level_high_i ? active_o : !active_o;
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import kwd_pkg::*;
#(
  parameter int unsigned PCLK_DIV    = 4,
  parameter int unsigned WIDTH_W     = 20,
  parameter logic [31:0] RESET_COUNT = 32'h014F_B180,
  parameter logic [31:0] RESET_SHAPE = 32'h0000_00FF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_valid,
  input  logic        bus_write,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        tick_1mhz_i,
  input  logic        inhibit_i,
  output logic        wdt_rst_o,
  output logic        wdt_irq_o,
  output logic        rst_push_pull_o
);
  logic [IDX_W-1:0]  idx;
  logic              wr, rd;
  logic [DATA_W-1:0] reload_q, reload_d;
  logic [DATA_W-1:0] ctrl_q, ctrl_d;
  logic [DATA_W-1:0] shape_q, shape_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              irq_q, irq_d;
  logic              ctrl_wr, en_rise, en_fall, restart_ok;
  logic              tick, expire, running, fire, pulse_active;
  logic [DATA_W-1:0] count;

  assign idx = bus_addr[7:2];
  assign wr  = bus_valid && bus_write;
  assign rd  = bus_valid && !bus_write;

  always_comb begin
    ctrl_wr    = wr && (idx == IDX_CTRL);
    en_rise    = ctrl_wr && bus_wdata[CB_EN] && !ctrl_q[CB_EN];
    en_fall    = ctrl_wr && !bus_wdata[CB_EN] && ctrl_q[CB_EN];
    restart_ok = wr && (idx == IDX_RESTART) && (bus_wdata[15:0] == RESTART_KEY);
    fire       = expire && !inhibit_i;
  end

  kwd_tick_sel #(.DIV(PCLK_DIV)) u_tick (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_ext_i  (ctrl_q[CB_TICK]),
    .ext_tick_i (tick_1mhz_i),
    .tick_o     (tick)
  );

  kwd_counter #(.CW(DATA_W), .RESET_COUNT(RESET_COUNT)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (en_rise || restart_ok),
    .run_set_i (en_rise || (restart_ok && ctrl_q[CB_EN])),
    .run_clr_i (en_fall),
    .reload_i  (reload_q),
    .tick_i    (tick),
    .count_o   (count),
    .run_o     (running),
    .expire_o  (expire)
  );

  kwd_pulse #(.WW(WIDTH_W)) u_pulse (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (fire && ctrl_q[CB_RST]),
    .width_i      (shape_q[WIDTH_W-1:0]),
    .level_high_i (shape_q[SB_HIGH]),
    .active_o     (pulse_active),
    .pin_o        (wdt_rst_o)
  );

  // register next-state
  always_comb begin
    reload_d = reload_q;
    if (wr && (idx == IDX_RELOAD)) reload_d = bus_wdata;

    ctrl_d = ctrl_q;
    if (ctrl_wr)                    ctrl_d = bus_wdata & ~CTRL_RSVD;
    else if (expire && inhibit_i)   ctrl_d = '0;

    shape_d = shape_q;
    if (wr && (idx == IDX_SHAPE)) begin
      shape_d[WIDTH_W-1:0] = bus_wdata[WIDTH_W-1:0];
      case (bus_wdata[31:24])
        KEY_HIGH_SET: shape_d[SB_HIGH] = 1'b1;
        KEY_HIGH_CLR: shape_d[SB_HIGH] = 1'b0;
        KEY_PP_SET:   shape_d[SB_PP]   = 1'b1;
        KEY_PP_CLR:   shape_d[SB_PP]   = 1'b0;
        default: ;
      endcase
    end

    irq_d = fire && ctrl_q[CB_IRQ];

    rdata_d = rdata_q;
    if (rd) begin
      case (idx)
        IDX_COUNT:  rdata_d = count;
        IDX_RELOAD: rdata_d = reload_q;
        IDX_CTRL:   rdata_d = ctrl_q;
        IDX_SHAPE:  rdata_d = shape_q;
        default:    rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= RESET_COUNT;
      ctrl_q   <= '0;
      shape_q  <= RESET_SHAPE;
      rdata_q  <= '0;
      irq_q    <= 1'b0;
    end else begin
      reload_q <= reload_d;
      ctrl_q   <= ctrl_d;
      shape_q  <= shape_d;
      rdata_q  <= rdata_d;
      irq_q    <= irq_d;
    end
  end

  assign bus_rdata       = rdata_q;
  assign wdt_irq_o       = irq_q;
  assign rst_push_pull_o = shape_q[SB_PP];
endmodule

// File: rtl/kwd_checker.sv
module kwd_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_valid,
  input logic        bus_write,
  input logic [7:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic        inhibit_i,
  input logic        wdt_irq_o,
  input logic [31:0] ctrl_q,
  input logic [31:0] count,
  input logic        running,
  input logic        expire,
  input logic        pulse_active
);
  // R9: interrupt never lasts more than one clock
  a_r9_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_irq_o |=> !wdt_irq_o);

  // R10: inhibited expiry clears the control word
  a_r10_inhibit_clears_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && inhibit_i) |=> (ctrl_q == 32'h0));

  // R6: a stopped counter with no bus traffic holds its value
  a_r6_idle_count_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !bus_valid) |=> $stable(count));

  // R2: a restart write with a wrong key does not touch a stopped count
  a_r2_bad_key_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && bus_addr[7:2] == 6'h02 &&
     bus_wdata[15:0] != 16'h4755 && !running) |=> $stable(count));

  // R8: no pulse starts when the reset enable is clear
  a_r8_no_pulse_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !ctrl_q[1] && !pulse_active) |=> !pulse_active);
endmodule

bind keyed_watchdog kwd_checker u_kwd_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_valid    (bus_valid),
  .bus_write    (bus_write),
  .bus_addr     (bus_addr),
  .bus_wdata    (bus_wdata),
  .inhibit_i    (inhibit_i),
  .wdt_irq_o    (wdt_irq_o),
  .ctrl_q       (ctrl_q),
  .count        (count),
  .running      (running),
  .expire       (expire),
  .pulse_active (pulse_active)
);

// File: tb/test_keyed_watchdog.sv
module test_keyed_watchdog;
  localparam int unsigned DIV = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tick_1mhz_i = 1'b0;
  logic        inhibit_i = 1'b0;
  logic        wdt_rst_o, wdt_irq_o, rst_push_pull_o;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  always #2.5 clk = ~clk;

  keyed_watchdog #(.PCLK_DIV(DIV)) i_keyed_watchdog (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_1mhz_i(tick_1mhz_i), .inhibit_i(inhibit_i), .wdt_rst_o(wdt_rst_o),
    .wdt_irq_o(wdt_irq_o), .rst_push_pull_o(rst_push_pull_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // all driver tasks start and end at a falling edge
  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    exp_t it;
    it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic tick();
    tick_1mhz_i = 1'b1;
    @(negedge clk);
    tick_1mhz_i = 1'b0;
  endtask

  // monitor: read data is registered at the edge that samples the request
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rst_n && bus_valid && !bus_write) begin
        exp_t it;
        it = sb_q.pop_front();
        check(it.tag, bus_rdata, it.exp);
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    logic irq2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    bus_rd(8'h00, 32'h014F_B180, "R1 count");
    bus_rd(8'h04, 32'h014F_B180, "R1 reload");
    bus_rd(8'h18, 32'h0000_00FF, "R1 shape");
    bus_rd(8'h0C, 32'h0, "R1 ctrl");
    check("R1 rst level", {31'b0, wdt_rst_o}, 32'h1);
    check("R1 push-pull", {31'b0, rst_push_pull_o}, 32'h0);

    // R2 restart key
    bus_wr(8'h04, 32'd5);
    bus_rd(8'h00, 32'h014F_B180, "R2 no load without restart");
    bus_wr(8'h08, 32'h0000_4756);
    bus_rd(8'h00, 32'h014F_B180, "R2 wrong key ignored");
    bus_wr(8'h08, 32'hABCD_4755);
    bus_rd(8'h00, 32'd5, "R2 key reloads");

    // R11 read-only / zero locations
    bus_wr(8'h00, 32'h77);
    bus_rd(8'h00, 32'd5, "R11 count write ignored");
    bus_wr(8'h40, 32'hFFFF_FFFF);
    bus_rd(8'h08, 32'h0, "R11 restart reads zero");
    bus_rd(8'h10, 32'h0, "R11 offset 0x10 zero");
    bus_rd(8'h14, 32'h0, "R11 offset 0x14 zero");
    bus_rd(8'h40, 32'h0, "R11 unmapped zero");

    // R4 reserved control bits
    bus_wr(8'h0C, 32'h0000_0390);
    bus_rd(8'h0C, 32'h0000_0010, "R4 bits 9:7 cleared");

    // R7 / R12 pulse-shape keys
    bus_wr(8'h18, 32'hA500_0003);
    bus_rd(8'h18, 32'h8000_0003, "R7 high key");
    check("R8 active-high idle level", {31'b0, wdt_rst_o}, 32'h0);
    bus_wr(8'h18, 32'hA800_0003);
    bus_rd(8'h18, 32'hC000_0003, "R7 push-pull key");
    check("R12 push-pull pin", {31'b0, rst_push_pull_o}, 32'h1);
    bus_wr(8'h18, 32'h12FF_FFFF);
    bus_rd(8'h18, 32'hC00F_FFFF, "R7 other top byte");
    bus_wr(8'h18, 32'h8A00_0002);
    bus_rd(8'h18, 32'h8000_0002, "R7 open-drain key");
    check("R12 open-drain pin", {31'b0, rst_push_pull_o}, 32'h0);
    bus_wr(8'h18, 32'h5A00_0003);
    bus_rd(8'h18, 32'h0000_0003, "R7 low key");
    bus_wr(8'h18, 32'hA500_0003);

    // R3 / R5 / R6 / R8 / R9 expiry with external tick
    bus_wr(8'h04, 32'd3);
    bus_wr(8'h0C, 32'h0000_0017);
    bus_rd(8'h00, 32'd3, "R3 enable loads reload");
    tick();
    bus_rd(8'h00, 32'd2, "R5 external tick decrements");
    tick();
    tick();
    check("R9 irq at expiry", {31'b0, wdt_irq_o}, 32'h1);
    n = 0; irq2 = 1'b1;
    while (wdt_rst_o && n < 100) begin
      if (n == 1) irq2 = wdt_irq_o;
      n++;
      @(negedge clk);
    end
    check("R8 pulse length width+1", n, 32'd4);
    check("R9 irq one cycle", {31'b0, irq2}, 32'h0);
    bus_rd(8'h00, 32'h0, "R6 count zero after expiry");
    tick();
    bus_rd(8'h00, 32'h0, "R6 stopped after expiry");
    bus_rd(8'h0C, 32'h17, "R3 ctrl kept after expiry");

    // R3 enable edges
    bus_wr(8'h08, 32'h0000_4755);
    bus_wr(8'h0C, 32'h0000_0016);
    tick();
    tick();
    bus_rd(8'h00, 32'd3, "R3 disable stops counting");
    bus_wr(8'h0C, 32'h0000_0016);
    bus_rd(8'h0C, 32'h16, "R3 same-enable store");
    bus_rd(8'h00, 32'd3, "R3 same-enable no reload");
    bus_wr(8'h04, 32'd2);
    bus_wr(8'h0C, 32'h0000_0017);
    bus_rd(8'h00, 32'd2, "R3 re-enable reloads");

    // R10 inhibited expiry
    inhibit_i = 1'b1;
    tick();
    tick();
    check("R10 no reset pulse", {31'b0, wdt_rst_o}, 32'h0);
    check("R10 no irq", {31'b0, wdt_irq_o}, 32'h0);
    inhibit_i = 1'b0;
    bus_rd(8'h0C, 32'h0, "R10 ctrl cleared");
    bus_rd(8'h00, 32'h0, "R10 count zero");

    // R8 no pulse when reset enable clear
    bus_wr(8'h04, 32'd1);
    bus_wr(8'h0C, 32'h0000_0015);
    tick();
    check("R9 irq without reset", {31'b0, wdt_irq_o}, 32'h1);
    check("R8 no pulse when disabled", {31'b0, wdt_rst_o}, 32'h0);
    @(negedge clk);
    check("R8 still no pulse", {31'b0, wdt_rst_o}, 32'h0);

    // R5 divided clock tick: any DIV-clock window has one tick
    bus_wr(8'h04, 32'd10);
    bus_wr(8'h0C, 32'h0000_0000);
    bus_wr(8'h0C, 32'h0000_0001);
    repeat (DIV) @(negedge clk);
    bus_rd(8'h00, 32'd9, "R5 divided tick");

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule